// File: doc/BRIEF.md
# Handshake Bus Master Sequencer

This block is the master side of a shared, fully handshaked bus. It carries one single-word read or write from the owning module onto the bus. The owning module gives it a start pulse together with an address, write data, a direction bit and a byte flag. The sequencer then does the following in order:

- It raises a service request.
- It waits until the arbiter selects it and the precedence pulse on the daisy chain reaches it.
- It acknowledges.
- It waits for the previous master to release the bus strobe.
- It puts address, control and (for a write) data on the bus.
- After a programmable settling delay, it raises its own strobe.

Acknowledge is released in the same cycle that strobe rises, so the arbiter can pick the next master while this transfer is still running.

The transfer ends when the responding slave signals done, or when the bus watchdog signals quit. Both inputs pass through a two-flop synchronizer. A quit leaves a sticky abort flag, meaning no slave answered. The precedence pulse passes down the daisy chain except while this master has a request pending. In the processor variant, a new request is held back while the shared processor-request line is still active from another requester, so that every processor gets a turn.

Top module: `hsbus_master`

## Requirements
- R1: After reset, all bus outputs (service request, acknowledge, strobe, drive-enable, address, write data, control bits) and the local done pulse and abort flag are 0.
- R2: The downstream precedence output equals the precedence input, except while the service request is high; then it is 0.
- R3: While requesting, seeing select and precedence both high in one cycle raises acknowledge and drops the service request on the next clock edge.
- R4: After acknowledging, address, control and data drive (drive-enable high) does not start while the incoming bus strobe is high.
- R5: Drive-enable stays high for exactly DESKEW cycles with strobe low. Then strobe rises, and acknowledge falls in that same cycle.
- R6: While drive-enable is high, the address output holds the latched address. The write control bit is 1 for a write and the byte control bit follows the byte flag. Write data is driven only for a write and is 0 for a read.
- R7: On the first rising edge of the synchronized done input during strobe, a read captures the bus read data into the local read-data output. In the same cycle all bus lines drop and a one-cycle done pulse is given with abort 0.
- R8: On a rising synchronized quit input during strobe (with done absent), all bus lines drop, the done pulse is given and the abort flag is set to 1. The flag stays 1 until the next accepted start clears it.
- R9: In the processor variant (PROC_TURN=1), the service request does not rise while the shared processor-request input is high, and rises once it is low.
- R10: A start pulse while a transfer is in progress is ignored. No second request follows, and the driven address is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| loc_start | input | 1 | One-cycle request to begin a transfer |
| loc_addr | input | AW | Transfer address |
| loc_wdata | input | DW | Write data |
| loc_write | input | 1 | 1 = write, 0 = read |
| loc_byte | input | 1 | Byte-size transfer flag |
| loc_rdata | output | DW | Data returned by the last read |
| loc_done | output | 1 | One-cycle completion pulse |
| loc_abort | output | 1 | Sticky flag: last transfer ended by quit |
| bus_sel | input | 1 | Select from the arbiter |
| bus_prec_in | input | 1 | Precedence pulse from upstream |
| bus_prec_out | output | 1 | Precedence pulse passed downstream |
| bus_strobe_in | input | 1 | Current bus strobe (other masters) |
| bus_done_in | input | 1 | Asynchronous done from slave |
| bus_quit_in | input | 1 | Asynchronous quit from bus watchdog |
| bus_rdata_in | input | DW | Read data from slave |
| bus_cpu_req_in | input | 1 | Shared processor-request line |
| bus_svc_req | output | 1 | Service request |
| bus_ack | output | 1 | Acknowledge of selection |
| bus_strobe_out | output | 1 | This master's strobe |
| bus_drive | output | 1 | Address/control/data lines valid |
| bus_addr | output | AW | Address lines |
| bus_wdata | output | DW | Write data lines |
| bus_wr | output | 1 | Write control line |
| bus_byte | output | 1 | Byte control line |

## Verification
The assertions take for granted that the arbiter asserts select and precedence only in answer to a pending service request. They also take for granted that the slave changes read data only before raising done, and that a done or quit pulse is held low long enough between transfers for the synchronizer to see a fresh rising edge. The stimulus plays the arbiter and the slave. It raises select and precedence for exactly one cycle after it sees the request. It holds the foreign strobe for a chosen number of cycles. It raises done or quit only after this master's strobe is seen, and it drops them before the next transfer starts.

// File: rtl/hsbus_pkg.sv
// Shared types for the handshake bus master.
// Assumes: nothing beyond IEEE 1800-2017.
package hsbus_pkg;

    // Sequencer states, in transfer order
    typedef enum logic [2:0] {
        MS_IDLE  = 3'd0,
        MS_TURN  = 3'd1,
        MS_REQ   = 3'd2,
        MS_ACK   = 3'd3,
        MS_SKEW  = 3'd4,
        MS_STRB  = 3'd5
    } mst_state_t;

endpackage

// File: rtl/hsbus_sync.sv
// Multi-stage flop synchronizer for a bundle of asynchronous single-bit inputs.
// Assumes: each bit is independent; no multi-bit coherence is needed.
module hsbus_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // first stage samples the raw inputs
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                // later stages shift the sampled value along
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/hsbus_chain.sv
// Daisy-chain precedence pass-through.
// Assumes: the precedence pulse is already in this clock domain.
module hsbus_chain (
    input  logic prec_in,
    input  logic requesting,
    output logic prec_out
);

    // forward the pulse downstream unless this master is claiming it
    always_comb begin
        prec_out = prec_in & ~requesting;
    end

endmodule

// File: rtl/hsbus_seq.sv
// Transfer sequencer: request, acknowledge, settle, strobe, complete.
// Assumes: done_s/quit_s are synchronized; start is one cycle wide.
module hsbus_seq
    import hsbus_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 16,
    parameter int DESKEW    = 2,
    parameter bit PROC_TURN = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          write,
    input  logic          byte_op,
    output logic [DW-1:0] rdata,
    output logic          done,
    output logic          abort,
    input  logic          sel,
    input  logic          prec_in,
    input  logic          strobe_in,
    input  logic          done_s,
    input  logic          quit_s,
    input  logic [DW-1:0] bus_rdata,
    input  logic          cpu_req_in,
    output logic          svc_req,
    output logic          ack,
    output logic          strobe_out,
    output logic          drive,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          bus_wr,
    output logic          bus_byte
);

    localparam int CW = (DESKEW > 1) ? $clog2(DESKEW) : 1;
    localparam logic [CW-1:0] SKEW_LAST = CW'(DESKEW - 1);

    mst_state_t    state;
    logic [CW-1:0] skew_cnt;
    logic [AW-1:0] lat_addr;
    logic [DW-1:0] lat_wdata;
    logic          lat_write;
    logic          lat_byte;
    logic          done_q;
    logic          quit_q;
    logic          done_rise;
    logic          quit_rise;
    logic          turn_block;

    generate
        if (PROC_TURN) begin : g_turn
            // processor variant: defer while another processor still requests
            assign turn_block = cpu_req_in;
        end else begin : g_noturn
            assign turn_block = 1'b0;
        end
    endgenerate

    // edge detection on the synchronized completion inputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            quit_q <= 1'b0;
        end else begin
            done_q <= done_s;
            quit_q <= quit_s;
        end
    end

    assign done_rise = done_s & ~done_q;
    assign quit_rise = quit_s & ~quit_q;

    // main sequencer, latched request and local results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= MS_IDLE;
            skew_cnt  <= '0;
            lat_addr  <= '0;
            lat_wdata <= '0;
            lat_write <= 1'b0;
            lat_byte  <= 1'b0;
            rdata     <= '0;
            done      <= 1'b0;
            abort     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                MS_IDLE: begin
                    if (start) begin
                        lat_addr  <= addr;
                        lat_wdata <= wdata;
                        lat_write <= write;
                        lat_byte  <= byte_op;
                        abort     <= 1'b0;
                        state     <= turn_block ? MS_TURN : MS_REQ;
                    end
                end
                MS_TURN: begin
                    if (!turn_block) state <= MS_REQ;
                end
                MS_REQ: begin
                    if (sel && prec_in) state <= MS_ACK;
                end
                MS_ACK: begin
                    if (!strobe_in) begin
                        skew_cnt <= '0;
                        state    <= MS_SKEW;
                    end
                end
                MS_SKEW: begin
                    if (skew_cnt == SKEW_LAST) state <= MS_STRB;
                    else                       skew_cnt <= skew_cnt + 1'b1;
                end
                MS_STRB: begin
                    if (done_rise) begin
                        if (!lat_write) rdata <= bus_rdata;
                        done  <= 1'b1;
                        state <= MS_IDLE;
                    end else if (quit_rise) begin
                        abort <= 1'b1;
                        done  <= 1'b1;
                        state <= MS_IDLE;
                    end
                end
                default: state <= MS_IDLE;
            endcase
        end
    end

    // bus line decode from the current state
    always_comb begin
        svc_req    = (state == MS_REQ);
        ack        = (state == MS_ACK) || (state == MS_SKEW);
        drive      = (state == MS_SKEW) || (state == MS_STRB);
        strobe_out = (state == MS_STRB);
        bus_addr   = drive ? lat_addr : '0;
        bus_wdata  = (drive && lat_write) ? lat_wdata : '0;
        bus_wr     = drive & lat_write;
        bus_byte   = drive & lat_byte;
    end

endmodule

// File: rtl/hsbus_master.sv
// Top of the handshake bus master: synchronizer, daisy-chain gate, sequencer.
// Assumes: done/quit are asynchronous; other bus inputs are in the clk domain.
module hsbus_master #(
    parameter int AW        = 16,
    parameter int DW        = 16,
    parameter int DESKEW    = 2,
    parameter int SYNC_FF   = 2,
    parameter bit PROC_TURN = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          loc_start,
    input  logic [AW-1:0] loc_addr,
    input  logic [DW-1:0] loc_wdata,
    input  logic          loc_write,
    input  logic          loc_byte,
    output logic [DW-1:0] loc_rdata,
    output logic          loc_done,
    output logic          loc_abort,
    input  logic          bus_sel,
    input  logic          bus_prec_in,
    output logic          bus_prec_out,
    input  logic          bus_strobe_in,
    input  logic          bus_done_in,
    input  logic          bus_quit_in,
    input  logic [DW-1:0] bus_rdata_in,
    input  logic          bus_cpu_req_in,
    output logic          bus_svc_req,
    output logic          bus_ack,
    output logic          bus_strobe_out,
    output logic          bus_drive,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          bus_wr,
    output logic          bus_byte
);

    logic [1:0] end_raw;
    logic [1:0] end_sync;

    assign end_raw = {bus_quit_in, bus_done_in};

    hsbus_sync #(.WIDTH(2), .STAGES(SYNC_FF)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (end_raw),
        .sync_out (end_sync)
    );

    hsbus_chain u_chain (
        .prec_in    (bus_prec_in),
        .requesting (bus_svc_req),
        .prec_out   (bus_prec_out)
    );

    hsbus_seq #(
        .AW(AW), .DW(DW), .DESKEW(DESKEW), .PROC_TURN(PROC_TURN)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (loc_start),
        .addr       (loc_addr),
        .wdata      (loc_wdata),
        .write      (loc_write),
        .byte_op    (loc_byte),
        .rdata      (loc_rdata),
        .done       (loc_done),
        .abort      (loc_abort),
        .sel        (bus_sel),
        .prec_in    (bus_prec_in),
        .strobe_in  (bus_strobe_in),
        .done_s     (end_sync[0]),
        .quit_s     (end_sync[1]),
        .bus_rdata  (bus_rdata_in),
        .cpu_req_in (bus_cpu_req_in),
        .svc_req    (bus_svc_req),
        .ack        (bus_ack),
        .strobe_out (bus_strobe_out),
        .drive      (bus_drive),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_wr     (bus_wr),
        .bus_byte   (bus_byte)
    );

endmodule

// File: rtl/hsbus_master_chk.sv
// Protocol checker for hsbus_master, attached by bind.
// Assumes: arbiter and slave behave as described in the brief.
module hsbus_master_chk #(
    parameter int AW        = 16,
    parameter int DESKEW    = 2,
    parameter bit PROC_TURN = 1'b1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_sel,
    input logic          bus_prec_in,
    input logic          bus_prec_out,
    input logic          bus_strobe_in,
    input logic          bus_cpu_req_in,
    input logic          bus_svc_req,
    input logic          bus_ack,
    input logic          bus_strobe_out,
    input logic          bus_drive,
    input logic [AW-1:0] bus_addr,
    input logic          loc_done
);

    logic [15:0] drive_run;

    // count how long the lines have been driven before strobe
    always_ff @(posedge clk) begin
        if (!rst_n)                          drive_run <= '0;
        else if (bus_drive && !bus_strobe_out) drive_run <= drive_run + 1'b1;
        else                                 drive_run <= '0;
    end

    // R2
    prec_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_prec_in && bus_svc_req) |-> !bus_prec_out);

    // R3
    ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ack) |-> $past(bus_sel && bus_prec_in && bus_svc_req) && !bus_svc_req);

    // R4
    drive_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_drive) |-> !$past(bus_strobe_in));

    // R5
    ack_handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_strobe_out) |-> ($past(bus_ack) && !bus_ack));

    // R5
    skew_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_strobe_out) |-> ($past(drive_run) == 16'(DESKEW - 1)) && $past(bus_drive));

    // R5
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_strobe_out && bus_ack));

    // R6
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_drive && $past(bus_drive)) |-> $stable(bus_addr));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loc_done |=> !loc_done);

    // R7
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loc_done |-> (!bus_drive && !bus_strobe_out && $past(bus_strobe_out)));

    // R9
    turn_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (PROC_TURN && $rose(bus_svc_req)) |-> !$past(bus_cpu_req_in));

endmodule

bind hsbus_master hsbus_master_chk #(
    .AW(AW), .DESKEW(DESKEW), .PROC_TURN(PROC_TURN)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_sel        (bus_sel),
    .bus_prec_in    (bus_prec_in),
    .bus_prec_out   (bus_prec_out),
    .bus_strobe_in  (bus_strobe_in),
    .bus_cpu_req_in (bus_cpu_req_in),
    .bus_svc_req    (bus_svc_req),
    .bus_ack        (bus_ack),
    .bus_strobe_out (bus_strobe_out),
    .bus_drive      (bus_drive),
    .bus_addr       (bus_addr),
    .loc_done       (loc_done)
);

// File: tb/test_hsbus_master.sv
// Directed bench: plays arbiter, foreign master and slave around hsbus_master.
module test_hsbus_master;

    localparam int AW     = 16;
    localparam int DW     = 16;
    localparam int DESKEW = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          loc_start;
    logic [AW-1:0] loc_addr;
    logic [DW-1:0] loc_wdata;
    logic          loc_write;
    logic          loc_byte;
    logic [DW-1:0] loc_rdata;
    logic          loc_done;
    logic          loc_abort;
    logic          bus_sel;
    logic          bus_prec_in;
    logic          bus_prec_out;
    logic          bus_strobe_in;
    logic          bus_done_in;
    logic          bus_quit_in;
    logic [DW-1:0] bus_rdata_in;
    logic          bus_cpu_req_in;
    logic          bus_svc_req;
    logic          bus_ack;
    logic          bus_strobe_out;
    logic          bus_drive;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_wr;
    logic          bus_byte;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    hsbus_master #(.AW(AW), .DW(DW), .DESKEW(DESKEW)) i_hsbus_master (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_for_req(input string req);
        int n = 0;
        while (!bus_svc_req && n < 50) begin @(negedge clk); n++; end
        check(req, {31'd0, bus_svc_req}, 32'd1);
    endtask

    // One full transfer with the bench acting as arbiter and slave.
    task automatic xfer(input logic wr, input logic bt, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic [DW-1:0] rd,
                        input logic use_quit, input int hold);
        int n;
        loc_write = wr; loc_byte = bt; loc_addr = a; loc_wdata = d;
        loc_start = 1'b1; @(negedge clk); loc_start = 1'b0;
        wait_for_req("R9 request raised");
        // R2: pulse must be blocked while requesting
        bus_prec_in = 1'b1; #1;
        check("R2 prec blocked", {31'd0, bus_prec_out}, 32'd0);
        bus_strobe_in = (hold > 0);
        bus_sel = 1'b1; @(negedge clk);
        bus_sel = 1'b0; bus_prec_in = 1'b0;
        check("R3 ack raised", {31'd0, bus_ack}, 32'd1);
        check("R3 request dropped", {31'd0, bus_svc_req}, 32'd0);
        for (int i = 0; i < hold; i++) begin
            check("R4 no drive under foreign strobe", {31'd0, bus_drive}, 32'd0);
            @(negedge clk);
        end
        bus_strobe_in = 1'b0;
        n = 0;
        while (!bus_drive && n < 20) begin @(negedge clk); n++; end
        n = 0;
        while (!bus_strobe_out && n < 20) begin
            if (bus_drive) n++;
            @(negedge clk);
        end
        check("R5 settle length", n, DESKEW);
        check("R5 ack released with strobe", {31'd0, bus_ack}, 32'd0);
        check("R6 address", {16'd0, bus_addr}, {16'd0, a});
        check("R6 write data", {16'd0, bus_wdata}, wr ? {16'd0, d} : 32'd0);
        check("R6 control", {30'd0, bus_wr, bus_byte}, {30'd0, wr, bt});
        bus_rdata_in = rd;
        @(negedge clk);
        if (use_quit) bus_quit_in = 1'b1; else bus_done_in = 1'b1;
        n = 0;
        while (!loc_done && n < 20) begin @(negedge clk); n++; end
        check(use_quit ? "R8 done pulse" : "R7 done pulse", {31'd0, loc_done}, 32'd1);
        check(use_quit ? "R8 lines dropped" : "R7 lines dropped",
              {30'd0, bus_strobe_out, bus_drive}, 32'd0);
        check(use_quit ? "R8 abort set" : "R7 abort clear", {31'd0, loc_abort}, {31'd0, use_quit});
        bus_done_in = 1'b0; bus_quit_in = 1'b0;
        @(negedge clk);
        check("R7 done is one cycle", {31'd0, loc_done}, 32'd0);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 idle outputs",
              {21'd0, bus_svc_req, bus_ack, bus_strobe_out, bus_drive, bus_wr, bus_byte,
               loc_done, loc_abort, 3'd0}, 32'd0);
        check("R1 address/data", {bus_addr, bus_wdata}, 32'd0);
        bus_prec_in = 1'b1; #1;
        check("R2 pass when idle", {31'd0, bus_prec_out}, 32'd1);
        bus_prec_in = 1'b0; @(negedge clk);
    endtask

    task automatic t_write;
        xfer(1'b1, 1'b0, 16'h1234, 16'hBEEF, 16'h0000, 1'b0, 3);
    endtask

    task automatic t_read;
        xfer(1'b0, 1'b1, 16'h00A5, 16'hFFFF, 16'h5A5A, 1'b0, 0);
        check("R7 read data", {16'd0, loc_rdata}, 32'h5A5A);
    endtask

    task automatic t_quit;
        xfer(1'b0, 1'b0, 16'h7F00, 16'h0, 16'h1111, 1'b1, 1);
        check("R8 read data kept", {16'd0, loc_rdata}, 32'h5A5A);
        check("R8 abort sticky", {31'd0, loc_abort}, 32'd1);
        xfer(1'b1, 1'b1, 16'h0002, 16'h00C3, 16'h0, 1'b0, 0);
        check("R8 abort cleared by next start", {31'd0, loc_abort}, 32'd0);
    endtask

    task automatic t_turn;
        bus_cpu_req_in = 1'b1;
        loc_write = 1'b0; loc_byte = 1'b0; loc_addr = 16'h0040;
        loc_start = 1'b1; @(negedge clk); loc_start = 1'b0;
        repeat (5) @(negedge clk);
        check("R9 held while shared line busy", {31'd0, bus_svc_req}, 32'd0);
        bus_cpu_req_in = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R9 request after shared line free", {31'd0, bus_svc_req}, 32'd1);
        bus_prec_in = 1'b1; bus_sel = 1'b1; @(negedge clk);
        bus_prec_in = 1'b0; bus_sel = 1'b0;
        while (!bus_strobe_out) @(negedge clk);
        // R10: start while busy must be ignored
        loc_addr = 16'hDEAD; loc_start = 1'b1; @(negedge clk); loc_start = 1'b0;
        check("R10 address unchanged", {16'd0, bus_addr}, 32'h0040);
        bus_rdata_in = 16'h0F0F; bus_done_in = 1'b1;
        while (!loc_done) @(negedge clk);
        bus_done_in = 1'b0;
        check("R7 read after turn", {16'd0, loc_rdata}, 32'h0F0F);
        repeat (8) @(negedge clk);
        check("R10 no second request", {29'd0, bus_svc_req, bus_ack, bus_drive}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; loc_start = 1'b0; loc_addr = '0; loc_wdata = '0;
        loc_write = 1'b0; loc_byte = 1'b0; bus_sel = 1'b0; bus_prec_in = 1'b0;
        bus_strobe_in = 1'b0; bus_done_in = 1'b0; bus_quit_in = 1'b0;
        bus_rdata_in = '0; bus_cpu_req_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write();
        t_read();
        t_quit();
        t_turn();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule